// File: doc/BRIEF.md
# Banked register complement unit

This unit carries out one instruction of an 8-bit accumulator machine: invert a data-memory byte. The result goes either to the working register (W) or back to the same memory location. A 16-bit instruction word is offered during the first quarter of each instruction cycle. The unit decodes it and builds a 12-bit data address from the 8-bit file field. The upper address bits come either from a bank number supplied by the surrounding core or from a fixed access bank. The unit reads the byte through a synchronous memory port, complements it and stores it at the chosen destination. It also updates the negative and zero flags. Any word that is not this instruction leaves every register, flag and memory location untouched.

A four-state machine divides each instruction cycle into four clock periods. PH_DECODE samples and decodes the word. PH_READ presents the read address. PH_PROCESS forms the inverted byte from the returned data. PH_WRITE drives the memory write or updates W and the flags. The transitions always run in the same order: PH_DECODE→PH_READ, PH_READ→PH_PROCESS, PH_PROCESS→PH_WRITE and PH_WRITE→PH_DECODE. Reset forces PH_DECODE. The current phase is visible on `q_phase`, so the core can offer the next instruction while `q_phase` is 0.

Top module: `bank_cmpl_unit`

## Requirements
- R1: `q_phase` steps 0 (PH_DECODE), 1 (PH_READ), 2 (PH_PROCESS), 3 (PH_WRITE) and back to 0, one step per clock. Reset holds it at 0.
- R2: During and after reset, W, N and Z read 0 and neither memory strobe is asserted.
- R3: An instruction is accepted when `instr_valid` is high at the clock edge that ends PH_DECODE and `instr[15:10]` equals 6'b000111. Bit 9 is the destination select d, bit 8 is the bank select a and bits 7:0 are the file field f.
- R4: With a = 1 the address used by the accepted instruction is {bank_sel[3:0], f}.
- R5: With a = 0, `bank_sel` has no effect. An f of 0x00–0x7F addresses bank 0 (0x000–0x07F) and an f of 0x80–0xFF addresses bank 15 (0xF80–0xFFF).
- R6: For an accepted instruction, `mem_rd_en` is high for exactly the PH_READ clock with the address from R4/R5. The data is taken from `mem_rdata` one clock later, during PH_PROCESS.
- R7: The result is the bitwise inverse of the byte read. With d = 0 it is loaded into W at the edge ending PH_WRITE, and no memory write occurs.
- R8: With d = 1, `mem_wr_en` is high for exactly the PH_WRITE clock, with `mem_wdata` equal to the result at the same address. W is unchanged.
- R9: At the edge ending PH_WRITE of an accepted instruction, N becomes result bit 7 and Z becomes 1 exactly when the result is 0x00, for either value of d. At no other edge do W, N or Z change.
- R10: A non-matching opcode, or `instr_valid` low, causes no read strobe, no write strobe and no change to W, N, Z or memory.
- R11: A byte of 0x13 complemented with d = 0 leaves the byte at 0x13 and sets W to 0xEC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, four periods per instruction cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word present, sampled at the end of PH_DECODE |
| instr | input | 16 | Instruction word |
| bank_sel | input | 4 | Current bank number used when a = 1 |
| q_phase | output | 2 | Current quarter phase (0..3) |
| mem_addr | output | 12 | Data-memory address |
| mem_rd_en | output | 1 | Synchronous read strobe, data returned next clock |
| mem_rdata | input | 8 | Read data from memory |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| w_reg | output | 8 | Working register |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
If the phase register skips or repeats a state, the memory strobes appear in the wrong quarter within the first instruction cycle. The byte that gets written or loaded is then stale or taken from the wrong address. A wrong captured destination or bank bit shows up at the end of that same instruction cycle: a missing or extra write strobe, a W change that should not happen, or a read address in the wrong bank. A stale context register lets an ignored word alter W, the flags or memory four clocks after it was offered. The bench therefore sweeps every file address under both bank modes and both destinations. It also offers every non-matching opcode, and it checks the strobes in each quarter as well as the state at the end of each cycle.

// File: rtl/cmpl_pkg.sv
package cmpl_pkg;
    typedef enum logic [1:0] {
        PH_DECODE  = 2'd0,
        PH_READ    = 2'd1,
        PH_PROCESS = 2'd2,
        PH_WRITE   = 2'd3
    } phase_e;
endpackage

// File: rtl/cmpl_decoder.sv
module cmpl_decoder #(
    parameter int OPC_W = 6,
    parameter int FILE_W = 8,
    parameter logic [OPC_W-1:0] OPC_CODE = 6'b000111,
    localparam int INSTR_W = OPC_W + 2 + FILE_W
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               hit,
    output logic               dst_file,
    output logic               use_bsr,
    output logic [FILE_W-1:0]  file_addr
);
    always_comb begin
        hit       = (instr[INSTR_W-1 -: OPC_W] == OPC_CODE);
        dst_file  = instr[FILE_W+1];
        use_bsr   = instr[FILE_W];
        file_addr = instr[FILE_W-1:0];
    end
endmodule

// File: rtl/cmpl_addr_gen.sv
module cmpl_addr_gen #(
    parameter int FILE_W = 8,
    parameter int BANK_W = 4,
    localparam int ADDR_W = BANK_W + FILE_W
) (
    input  logic              use_bsr,
    input  logic [FILE_W-1:0] file_addr,
    input  logic [BANK_W-1:0] bank_sel,
    output logic [ADDR_W-1:0] eff_addr
);
    logic [BANK_W-1:0] access_bank;

    // Access bank: lower half of f maps to the lowest bank, upper half to the highest.
    always_comb begin
        access_bank = {BANK_W{file_addr[FILE_W-1]}};
        eff_addr    = {(use_bsr ? bank_sel : access_bank), file_addr};
    end
endmodule

// File: rtl/cmpl_sequencer.sv
module cmpl_sequencer
    import cmpl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase
);
    phase_e state_q;
    phase_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_DECODE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_DECODE:  state_d = PH_READ;
            PH_READ:    state_d = PH_PROCESS;
            PH_PROCESS: state_d = PH_WRITE;
            PH_WRITE:   state_d = PH_DECODE;
        endcase
    end

    always_comb begin
        phase = state_q;
    end

    assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_WRITE) |=> (2'(phase) == 2'(2'($past(phase)) + 2'd1)));

    assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WRITE) |=> (phase == PH_DECODE));
endmodule

// File: rtl/bank_cmpl_unit.sv
module bank_cmpl_unit
    import cmpl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int FILE_W = 8,
    parameter int BANK_W = 4,
    parameter int OPC_W  = 6,
    parameter logic [OPC_W-1:0] OPC_CODE = 6'b000111,
    localparam int INSTR_W = OPC_W + 2 + FILE_W,
    localparam int ADDR_W  = BANK_W + FILE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [BANK_W-1:0]  bank_sel,
    output logic [1:0]         q_phase,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_rd_en,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               mem_wr_en,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic [DATA_W-1:0]  w_reg,
    output logic               flag_n,
    output logic               flag_z
);
    phase_e phase;

    logic              dec_hit;
    logic              dec_dst;
    logic              dec_bsr;
    logic [FILE_W-1:0] dec_file;
    logic [ADDR_W-1:0] dec_addr;

    logic              ctx_hit;
    logic              ctx_dst;
    logic [ADDR_W-1:0] ctx_addr;
    logic [DATA_W-1:0] result_q;
    logic [DATA_W-1:0] w_q;
    logic              n_q;
    logic              z_q;

    cmpl_sequencer u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    cmpl_decoder #(
        .OPC_W    (OPC_W),
        .FILE_W   (FILE_W),
        .OPC_CODE (OPC_CODE)
    ) u_dec (
        .instr     (instr),
        .hit       (dec_hit),
        .dst_file  (dec_dst),
        .use_bsr   (dec_bsr),
        .file_addr (dec_file)
    );

    cmpl_addr_gen #(
        .FILE_W (FILE_W),
        .BANK_W (BANK_W)
    ) u_agen (
        .use_bsr   (dec_bsr),
        .file_addr (dec_file),
        .bank_sel  (bank_sel),
        .eff_addr  (dec_addr)
    );

    // Per-phase datapath work.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_hit  <= 1'b0;
            ctx_dst  <= 1'b0;
            ctx_addr <= '0;
            result_q <= '0;
            w_q      <= '0;
            n_q      <= 1'b0;
            z_q      <= 1'b0;
        end else begin
            unique case (phase)
                PH_DECODE: begin
                    ctx_hit  <= instr_valid && dec_hit;
                    ctx_dst  <= dec_dst;
                    ctx_addr <= dec_addr;
                end
                PH_READ: begin
                end
                PH_PROCESS: begin
                    if (ctx_hit) result_q <= ~mem_rdata;
                end
                PH_WRITE: begin
                    if (ctx_hit) begin
                        if (!ctx_dst) w_q <= result_q;
                        n_q <= result_q[DATA_W-1];
                        z_q <= (result_q == '0);
                    end
                end
            endcase
        end
    end

    always_comb begin
        q_phase   = phase;
        mem_addr  = ctx_addr;
        mem_rd_en = ctx_hit && (phase == PH_READ);
        mem_wr_en = ctx_hit && ctx_dst && (phase == PH_WRITE);
        mem_wdata = result_q;
        w_reg     = w_q;
        flag_n    = n_q;
        flag_z    = z_q;
    end

    assert_rd_then_process_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (phase == PH_PROCESS));

    assert_wdata_inverse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ((mem_wdata ^ $past(mem_rdata)) == {DATA_W{1'b1}}));

    assert_single_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> !mem_wr_en);

    assert_w_kept_on_file_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> $stable(w_reg));

    assert_state_only_at_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_WRITE) |=> $stable({w_reg, flag_n, flag_z}));

    assert_no_strobe_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));
endmodule

// File: tb/bank_cmpl_unit_bench.sv
`timescale 1ns/1ps
module bank_cmpl_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [3:0]  bank_sel = '0;
    logic [1:0]  q_phase;
    logic [11:0] mem_addr;
    logic        mem_rd_en;
    logic [7:0]  mem_rdata = '0;
    logic        mem_wr_en;
    logic [7:0]  mem_wdata;
    logic [7:0]  w_reg;
    logic        flag_n;
    logic        flag_z;

    logic [7:0] mem     [0:4095];
    logic [7:0] exp_mem [0:4095];
    logic [7:0] exp_w = '0;
    logic       exp_n = 1'b0;
    logic       exp_z = 1'b0;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    bank_cmpl_unit u_bank_cmpl_unit (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .bank_sel(bank_sel), .q_phase(q_phase), .mem_addr(mem_addr),
        .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en),
        .mem_wdata(mem_wdata), .w_reg(w_reg), .flag_n(flag_n), .flag_z(flag_z)
    );

    initial begin
        for (int a = 0; a < 4096; a++) begin
            mem[a]     = 8'(a) ^ {4'(a >> 8), 4'(a >> 8)};
            exp_mem[a] = 8'(a) ^ {4'(a >> 8), 4'(a >> 8)};
        end
    end

    always @(posedge clk) begin
        if (mem_wr_en) mem[mem_addr] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Offer one word and check each quarter plus the end state.
    task automatic exec(input logic vld, input logic [15:0] word, input logic [3:0] bsr);
        logic        acc;
        logic        d;
        logic [11:0] ea;
        logic [7:0]  res;
        while (q_phase != 2'd0) @(negedge clk);
        acc = vld && (word[15:10] == 6'b000111);
        d   = word[9];
        ea  = word[8] ? {bsr, word[7:0]} : {{4{word[7]}}, word[7:0]};
        res = ~exp_mem[ea];
        instr_valid = vld; instr = word; bank_sel = bsr;
        @(negedge clk);
        instr_valid = 1'b0; instr = 16'h0000; bank_sel = ~bsr;
        chk(q_phase == 2'd1, "R1 read phase", q_phase, 1);
        chk(mem_rd_en == acc, acc ? "R6 read strobe" : "R10 no read", mem_rd_en, acc);
        if (acc) chk(mem_addr == ea, word[8] ? "R4 bsr address" : "R5 access address", mem_addr, ea);
        chk(!mem_wr_en, "R6 no write in read", mem_wr_en, 0);
        @(negedge clk);
        chk(q_phase == 2'd2, "R1 process phase", q_phase, 2);
        chk(!mem_rd_en && !mem_wr_en, "R6 quiet process", {mem_rd_en, mem_wr_en}, 0);
        @(negedge clk);
        chk(q_phase == 2'd3, "R1 write phase", q_phase, 3);
        chk(mem_wr_en == (acc && d), d ? "R8 write strobe" : "R7 no write", mem_wr_en, acc && d);
        if (acc && d) begin
            chk(mem_wdata == res, "R8 write data", mem_wdata, res);
            chk(mem_addr == ea, "R8 write address", mem_addr, ea);
        end
        @(negedge clk);
        if (acc) begin
            if (d) exp_mem[ea] = res; else exp_w = res;
            exp_n = res[7];
            exp_z = (res == 8'h00);
        end
        chk(q_phase == 2'd0, "R1 wrap", q_phase, 0);
        chk(w_reg == exp_w, acc ? (d ? "R8 W kept" : "R7 W result") : "R10 W kept", w_reg, exp_w);
        chk(flag_n == exp_n, acc ? "R9 N flag" : "R10 N kept", flag_n, exp_n);
        chk(flag_z == exp_z, acc ? "R9 Z flag" : "R10 Z kept", flag_z, exp_z);
        chk(mem[ea] == exp_mem[ea], acc ? "R7 R8 memory" : "R10 memory kept", mem[ea], exp_mem[ea]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(q_phase == 2'd0, "R1 reset phase", q_phase, 0);
        chk(w_reg == 8'h00 && !flag_n && !flag_z, "R2 reset state", {w_reg, flag_n, flag_z}, 0);
        chk(!mem_rd_en && !mem_wr_en, "R2 reset strobes", {mem_rd_en, mem_wr_en}, 0);
        rst_n = 1'b1;
        // Worked example: byte 0x13 at 0x013, d=0, a=0.
        exec(1'b1, 16'h1C13, 4'h7);
        chk(w_reg == 8'hEC, "R11 W", w_reg, 8'hEC);
        chk(mem[12'h013] == 8'h13, "R11 byte kept", mem[12'h013], 8'h13);
        // R3 R4 R5: sweep every f under both bank modes and destinations.
        for (int b = 0; b < 3; b++) begin
            for (int f = 0; f < 256; f++) begin
                for (int m = 0; m < 4; m++) begin
                    exec(1'b1, {6'b000111, 2'(m), 8'(f)}, (b == 0) ? 4'h0 : (b == 1) ? 4'h5 : 4'hF);
                end
            end
        end
        // R10: every other opcode, and a matching word with valid low.
        for (int op = 0; op < 64; op++) begin
            if (op != 7) exec(1'b1, {6'(op), 2'(op), 8'(op * 13)}, 4'(op));
        end
        exec(1'b0, 16'h1E42, 4'h3);
        exec(1'b0, 16'h1C80, 4'h0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule